// File: doc/BRIEF.md
# Transmit Mailbox Priority Arbiter

This block owns a small group of transmit mailboxes and decides which one is handed next to a CAN protocol engine. Each mailbox holds a frame identifier, a payload length code, a remote-frame flag, a transmit-mode enable and a 4-bit priority. Software arms a mailbox with a start request. While the engine is idle, the arbiter looks at every armed, enabled mailbox. It picks the one with the numerically smallest priority value. If two or more share that value, it picks the one with the lowest index.

The chosen frame is copied into output registers and presented to the engine. It stays there until the engine reports that the transfer has finished, either as a success or as an abort. A newly armed mailbox never displaces a frame that is already presented. On completion the mailbox becomes ready again and records whether the transfer was aborted. It also sets a completion event bit, which drives the interrupt line when the matching enable bit is set.

The identifier of a mailbox can only be changed while that mailbox is out of transmit mode. Software therefore disables the mailbox, writes the identifier, and then enables it again with its priority. The mailboxes are numbered 12 to 15 on the engine side, and bit i of every status vector belongs to mailbox 12+i.

Top module: `tx_mb_arbiter`

## Requirements
- R1: After reset, all mailboxes are ready (`mb_ready` = 4'b1111) and out of transmit mode. `mb_aborted`, `mb_event`, `eng_valid` and `irq` are all 0.
- R2: When bit i of `go_mask` is set and mailbox i is enabled and ready, mailbox i becomes armed. Its ready bit clears at the next edge, and it latches `go_len` and `go_rtr`. That length and remote flag appear on `eng_len` and `eng_rtr` when the frame is presented.
- R3: A start request is ignored if the mailbox is out of transmit mode, or if it is already armed. In both cases the ready bit and the pending state are unchanged.
- R4: An identifier write (`id_we`) is applied only while the addressed mailbox is out of transmit mode. A write to an enabled mailbox is ignored.
- R5: Among the armed, enabled mailboxes, the one with the smallest priority value is presented first. Priority 0 is the highest and 15 the lowest.
- R6: When armed, enabled mailboxes share the smallest priority value, the lowest mailbox index wins.
- R7: While the engine is idle and a candidate exists, `eng_valid` rises at the next clock edge. `eng_mb` then equals 12 plus the local index, and `eng_id`, `eng_len` and `eng_rtr` come from that mailbox.
- R8: A presented frame stays presented, with `eng_mb` and `eng_id` unchanged, until `eng_done`. This holds even if a higher-priority mailbox is armed in the meantime.
- R9: When `eng_done` arrives, the presented mailbox becomes ready, its aborted bit takes the value of `eng_abort`, and its event bit sets. `irq` is high while any event bit is set and enabled in `irq_en`.
- R10: An accepted start request clears that mailbox's aborted bit and event bit.
- R11: An armed mailbox that is taken out of transmit mode is not selected. It is selected once it is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| cfg_we | input | 1 | Mode/priority write strobe |
| cfg_idx | input | 2 | Local mailbox index for the mode/priority write |
| cfg_en | input | 1 | 1 = transmit mode, 0 = disabled |
| cfg_prio | input | 4 | Priority (0 highest) |
| id_we | input | 1 | Identifier write strobe |
| id_idx | input | 2 | Local mailbox index for the identifier write |
| id_val | input | 29 | Identifier value |
| go_mask | input | 4 | Start request, one bit per mailbox |
| go_len | input | 4 | Length code latched on an accepted start |
| go_rtr | input | 1 | Remote flag latched on an accepted start |
| eng_valid | output | 1 | A frame is presented to the engine |
| eng_mb | output | 4 | Mailbox number (12 to 15) of the presented frame |
| eng_id | output | 29 | Identifier of the presented frame |
| eng_len | output | 4 | Length code of the presented frame |
| eng_rtr | output | 1 | Remote flag of the presented frame |
| eng_done | input | 1 | Engine reports the end of the presented transfer |
| eng_abort | input | 1 | With `eng_done`: the transfer was aborted |
| mb_ready | output | 4 | Per-mailbox ready (1 = free or finished) |
| mb_aborted | output | 4 | Per-mailbox: the last transfer was aborted |
| mb_event | output | 4 | Per-mailbox completion event |
| irq_en | input | 4 | Per-mailbox interrupt enable |
| irq | output | 1 | OR of enabled event bits |

## Verification
The selection logic is driven by a table of priority sets and arm masks. The table covers all-equal priorities, strictly descending priorities, and one unique best among equals. It also covers extreme values 0 and 15 with gaps in the mask, and single-mailbox arming. Each entry is drained frame by frame against a hand-worked order, which separates a value-first comparison from an index-first one and shows whether ties resolve to the lower index. Directed sequences then cover the cases the table cannot reach: a late higher-priority arm during a transfer (no preemption), arming a disabled or busy mailbox, an identifier write while enabled, an abort with its status and interrupt, and disabling a mailbox while it is armed.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;
  // Arbiter control state: idle (free to select) or presenting a frame.
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;
endpackage

// File: rtl/tx_mb_slot.sv
module tx_mb_slot #(
  parameter int PRIO_W = 4,
  parameter int ID_W   = 29,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              id_we,
  input  logic [ID_W-1:0]   id_val,
  input  logic              go_we,
  input  logic [LEN_W-1:0]  go_len,
  input  logic              go_rtr,
  input  logic              fin,
  input  logic              fin_abort,
  output logic              en,
  output logic [PRIO_W-1:0] prio,
  output logic [ID_W-1:0]   id,
  output logic [LEN_W-1:0]  len,
  output logic              rtr,
  output logic              pend,
  output logic              aborted,
  output logic              evt
);
  logic              en_q, en_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              rtr_q, rtr_d;
  logic              pend_q, pend_d;
  logic              abt_q, abt_d;
  logic              evt_q, evt_d;
  logic              go_ok;

  assign go_ok = go_we && en_q && !pend_q;

  always_comb begin
    en_d   = en_q;
    prio_d = prio_q;
    id_d   = id_q;
    len_d  = len_q;
    rtr_d  = rtr_q;
    pend_d = pend_q;
    abt_d  = abt_q;
    evt_d  = evt_q;
    if (cfg_we) begin
      en_d   = cfg_en;
      prio_d = cfg_prio;
    end
    if (id_we && !en_q) id_d = id_val;
    if (go_ok) begin
      pend_d = 1'b1;
      abt_d  = 1'b0;
      evt_d  = 1'b0;
      len_d  = go_len;
      rtr_d  = go_rtr;
    end
    if (fin) begin
      pend_d = 1'b0;
      abt_d  = fin_abort;
      evt_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      prio_q <= '0;
      id_q   <= '0;
      len_q  <= '0;
      rtr_q  <= 1'b0;
      pend_q <= 1'b0;
      abt_q  <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      prio_q <= prio_d;
      id_q   <= id_d;
      len_q  <= len_d;
      rtr_q  <= rtr_d;
      pend_q <= pend_d;
      abt_q  <= abt_d;
      evt_q  <= evt_d;
    end
  end

  assign en      = en_q;
  assign prio    = prio_q;
  assign id      = id_q;
  assign len     = len_q;
  assign rtr     = rtr_q;
  assign pend    = pend_q;
  assign aborted = abt_q;
  assign evt     = evt_q;

  AST_ABORT_ONLY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    abt_q |-> !pend_q); // R9
  AST_FIN_ONLY_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> pend_q); // R9
  AST_GO_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    go_ok |=> pend_q && !abt_q && !evt_q); // R10
endmodule

// File: rtl/tx_prio_pick.sv
module tx_prio_pick #(
  parameter int NUM_MB = 4,
  parameter int PRIO_W = 4,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic [NUM_MB-1:0]        cand,
  input  logic [NUM_MB*PRIO_W-1:0] prio_flat,
  output logic                     any,
  output logic [IDX_W-1:0]         win
);
  logic [PRIO_W-1:0] best;

  // Strict less-than keeps the earliest (lowest) index on equal values.
  always_comb begin
    any  = 1'b0;
    win  = '0;
    best = '1;
    for (int i = 0; i < NUM_MB; i++) begin
      if (cand[i] && (!any || prio_flat[i*PRIO_W +: PRIO_W] < best)) begin
        any  = 1'b1;
        best = prio_flat[i*PRIO_W +: PRIO_W];
        win  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tx_mb_arbiter.sv
module tx_mb_arbiter
  import tx_arb_pkg::*;
#(
  parameter int NUM_MB   = 4,
  parameter int FIRST_MB = 12,
  parameter int PRIO_W   = 4,
  parameter int ID_W     = 29,
  parameter int LEN_W    = 4,
  localparam int IDX_W   = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
  localparam int MB_W    = $clog2(FIRST_MB + NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              id_we,
  input  logic [IDX_W-1:0]  id_idx,
  input  logic [ID_W-1:0]   id_val,
  input  logic [NUM_MB-1:0] go_mask,
  input  logic [LEN_W-1:0]  go_len,
  input  logic              go_rtr,
  output logic              eng_valid,
  output logic [MB_W-1:0]   eng_mb,
  output logic [ID_W-1:0]   eng_id,
  output logic [LEN_W-1:0]  eng_len,
  output logic              eng_rtr,
  input  logic              eng_done,
  input  logic              eng_abort,
  output logic [NUM_MB-1:0] mb_ready,
  output logic [NUM_MB-1:0] mb_aborted,
  output logic [NUM_MB-1:0] mb_event,
  input  logic [NUM_MB-1:0] irq_en,
  output logic              irq
);
  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_MB-1:0]        slot_en, slot_pend, slot_rtr, fin;
  logic [NUM_MB*PRIO_W-1:0] prio_flat;
  logic [ID_W-1:0]          slot_id  [NUM_MB];
  logic [LEN_W-1:0]         slot_len [NUM_MB];

  arb_state_e       state_q, state_d;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             rtr_q, rtr_d;
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic             busy;

  assign busy = (state_q == ARB_BUSY);

  for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
    assign fin[g] = busy && eng_done && (sel_q == IDX_W'(g));
    tx_mb_slot #(.PRIO_W(PRIO_W), .ID_W(ID_W), .LEN_W(LEN_W)) slot_i (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .cfg_we   (cfg_we && (cfg_idx == IDX_W'(g))),
      .cfg_en   (cfg_en),
      .cfg_prio (cfg_prio),
      .id_we    (id_we && (id_idx == IDX_W'(g))),
      .id_val   (id_val),
      .go_we    (go_mask[g]),
      .go_len   (go_len),
      .go_rtr   (go_rtr),
      .fin      (fin[g]),
      .fin_abort(eng_abort),
      .en       (slot_en[g]),
      .prio     (prio_flat[g*PRIO_W +: PRIO_W]),
      .id       (slot_id[g]),
      .len      (slot_len[g]),
      .rtr      (slot_rtr[g]),
      .pend     (slot_pend[g]),
      .aborted  (mb_aborted[g]),
      .evt      (mb_event[g])
    );
  end

  tx_prio_pick #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W)) pick_i (
    .cand     (slot_en & slot_pend),
    .prio_flat(prio_flat),
    .any      (pick_any),
    .win      (pick_idx)
  );

  // Next state: select only while idle, hold until the engine finishes.
  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    id_d    = id_q;
    len_d   = len_q;
    rtr_d   = rtr_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (pick_any) begin
          state_d = ARB_BUSY;
          sel_d   = pick_idx;
          id_d    = slot_id[pick_idx];
          len_d   = slot_len[pick_idx];
          rtr_d   = slot_rtr[pick_idx];
        end
      end
      ARB_BUSY: begin
        if (eng_done) state_d = ARB_IDLE;
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ARB_IDLE;
      sel_q   <= '0;
      id_q    <= '0;
      len_q   <= '0;
      rtr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      id_q    <= id_d;
      len_q   <= len_d;
      rtr_q   <= rtr_d;
    end
  end

  assign eng_valid = busy;
  assign eng_mb    = MB_W'(FIRST_MB) + MB_W'(sel_q);
  assign eng_id    = id_q;
  assign eng_len   = len_q;
  assign eng_rtr   = rtr_q;
  assign mb_ready  = ~slot_pend;
  assign irq       = |(mb_event & irq_en);

  AST_PRESENTED_IS_ARMED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eng_valid |-> !mb_ready[sel_q]); // R7
  AST_IDLE_GRANTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!eng_valid && |(slot_en & ~mb_ready)) |=> eng_valid); // R7
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eng_valid && !eng_done) |=> eng_valid && $stable(eng_mb) && $stable(eng_id)); // R8
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eng_valid && eng_done) |=> !eng_valid && mb_ready[$past(sel_q)]
                                && mb_event[$past(sel_q)]); // R9
endmodule

// File: tb/tx_mb_arbiter_tb_top.sv
module tx_mb_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int NVEC       = 8;

  // Vector layout: [31:16] priorities (mailbox i at 16+4i), [15:12] arm mask,
  // [11:0] expected drain order, slot k at 3k; value 7 = nothing more.
  localparam logic [31:0] VEC [NVEC] = '{
    {4'd0,  4'd0,  4'd0,  4'd0,  4'b1111, 3'd3, 3'd2, 3'd1, 3'd0},
    {4'd0,  4'd1,  4'd2,  4'd3,  4'b1111, 3'd0, 3'd1, 3'd2, 3'd3},
    {4'd5,  4'd2,  4'd5,  4'd5,  4'b1111, 3'd3, 3'd1, 3'd0, 3'd2},
    {4'd0,  4'd15, 4'd0,  4'd15, 4'b1011, 3'd7, 3'd0, 3'd3, 3'd1},
    {4'd7,  4'd7,  4'd7,  4'd7,  4'b0100, 3'd7, 3'd7, 3'd7, 3'd2},
    {4'd15, 4'd1,  4'd15, 4'd0,  4'b1110, 3'd7, 3'd3, 3'd1, 3'd2},
    {4'd1,  4'd4,  4'd4,  4'd9,  4'b0110, 3'd7, 3'd7, 3'd2, 3'd1},
    {4'd15, 4'd15, 4'd15, 4'd15, 4'b1001, 3'd7, 3'd7, 3'd3, 3'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_en, id_we, go_rtr, eng_done, eng_abort;
  logic [1:0]  cfg_idx, id_idx;
  logic [3:0]  cfg_prio, go_mask, go_len, irq_en;
  logic [28:0] id_val;
  logic        eng_valid, eng_rtr, irq;
  logic [3:0]  eng_mb, eng_len, mb_ready, mb_aborted, mb_event;
  logic [28:0] eng_id;

  int n_chk  = 0;
  int n_fail = 0;
  bit over   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_mb_arbiter dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_prio(cfg_prio),
    .id_we(id_we), .id_idx(id_idx), .id_val(id_val),
    .go_mask(go_mask), .go_len(go_len), .go_rtr(go_rtr),
    .eng_valid(eng_valid), .eng_mb(eng_mb), .eng_id(eng_id),
    .eng_len(eng_len), .eng_rtr(eng_rtr),
    .eng_done(eng_done), .eng_abort(eng_abort),
    .mb_ready(mb_ready), .mb_aborted(mb_aborted), .mb_event(mb_event),
    .irq_en(irq_en), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input logic en, input logic [3:0] p);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_en = en; cfg_prio = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idwr(input int idx, input logic [28:0] v);
    id_we = 1'b1; id_idx = 2'(idx); id_val = v;
    @(negedge clk);
    id_we = 1'b0;
  endtask

  task automatic go(input logic [3:0] m, input logic [3:0] l, input logic r);
    go_mask = m; go_len = l; go_rtr = r;
    @(negedge clk);
    go_mask = '0;
  endtask

  task automatic wait_valid();
    for (int c = 0; c < 6 && !eng_valid; c++) @(negedge clk);
  endtask

  task automatic done_pulse(input logic ab);
    eng_done = 1'b1; eng_abort = ab;
    @(negedge clk);
    eng_done = 1'b0; eng_abort = 1'b0;
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b1;
    cfg_we = 0; cfg_idx = 0; cfg_en = 0; cfg_prio = 0;
    id_we = 0; id_idx = 0; id_val = 0;
    go_mask = 0; go_len = 0; go_rtr = 0;
    eng_done = 0; eng_abort = 0; irq_en = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 ready", 32'(mb_ready), 32'hF);
    chk("R1 aborted", 32'(mb_aborted), 32'h0);
    chk("R1 event", 32'(mb_event), 32'h0);
    chk("R1 valid", 32'(eng_valid), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R3 start on disabled mailbox ignored
    go(4'b0001, 4'd2, 1'b0);
    repeat (3) @(negedge clk);
    chk("R3 disabled ready", 32'(mb_ready), 32'hF);
    chk("R3 disabled valid", 32'(eng_valid), 32'h0);

    // R4 identifier write only while disabled; R2 latching
    idwr(0, 29'h123);
    cfg(0, 1'b1, 4'd0);
    idwr(0, 29'h456);
    go(4'b0001, 4'd5, 1'b1);
    chk("R2 ready clears", 32'(mb_ready), 32'hE);
    wait_valid();
    chk("R7 mb", 32'(eng_mb), 32'd12);
    chk("R4 id", 32'(eng_id), 32'h123);
    chk("R2 len", 32'(eng_len), 32'd5);
    chk("R2 rtr", 32'(eng_rtr), 32'd1);
    // R3 second start while armed is ignored
    go(4'b0001, 4'd9, 1'b0);
    done_pulse(1'b0);
    chk("R9 ready", 32'(mb_ready), 32'hF);
    chk("R9 event", 32'(mb_event[0]), 32'd1);
    chk("R9 aborted", 32'(mb_aborted[0]), 32'd0);
    repeat (3) @(negedge clk);
    chk("R3 armed restart ignored", 32'(eng_valid), 32'd0);
    chk("R9 irq masked", 32'(irq), 32'd0);
    irq_en = 4'b0001; #1;
    chk("R9 irq enabled", 32'(irq), 32'd1);
    irq_en = 4'b0000;
    @(negedge clk);

    // R5 R6 table walk
    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < 4; i++) cfg(i, 1'b1, VEC[v][16+4*i +: 4]);
      go(VEC[v][15:12], 4'(v), 1'b0);
      for (int k = 0; k < 4; k++) begin
        automatic logic [2:0] o = VEC[v][3*k +: 3];
        if (o == 3'd7) begin
          repeat (3) @(negedge clk);
          chk($sformatf("R5 R6 vec%0d slot%0d none", v, k), 32'(eng_valid), 32'd0);
        end else begin
          wait_valid();
          chk($sformatf("R5 R6 vec%0d slot%0d", v, k), 32'(eng_mb), 32'd12 + 32'(o));
          done_pulse(1'b0);
        end
      end
      chk($sformatf("R9 vec%0d drained", v), 32'(mb_ready), 32'hF);
    end

    // R8 no preemption
    cfg(0, 1'b1, 4'd0);
    cfg(1, 1'b1, 4'd5);
    go(4'b0010, 4'd1, 1'b0);
    wait_valid();
    chk("R8 first", 32'(eng_mb), 32'd13);
    go(4'b0001, 4'd1, 1'b0);
    repeat (4) @(negedge clk);
    chk("R8 held", 32'(eng_mb), 32'd13);
    chk("R8 valid", 32'(eng_valid), 32'd1);
    done_pulse(1'b0);
    wait_valid();
    chk("R8 next", 32'(eng_mb), 32'd12);
    done_pulse(1'b1);
    chk("R9 abort flag", 32'(mb_aborted[0]), 32'd1);
    chk("R9 abort event", 32'(mb_event[0]), 32'd1);

    // R10 new start clears aborted and event
    irq_en = 4'b0001;
    go(4'b0001, 4'd2, 1'b0);
    chk("R10 aborted cleared", 32'(mb_aborted[0]), 32'd0);
    chk("R10 event cleared", 32'(mb_event[0]), 32'd0);
    chk("R10 irq low", 32'(irq), 32'd0);
    wait_valid();
    done_pulse(1'b0);
    irq_en = 4'b0000;

    // R11 disabled armed mailbox not selected
    go(4'b0001, 4'd1, 1'b0);
    wait_valid();
    go(4'b0100, 4'd1, 1'b0);
    cfg(2, 1'b0, 4'd3);
    done_pulse(1'b0);
    repeat (3) @(negedge clk);
    chk("R11 not selected", 32'(eng_valid), 32'd0);
    chk("R11 still armed", 32'(mb_ready[2]), 32'd0);
    cfg(2, 1'b1, 4'd3);
    wait_valid();
    chk("R11 selected after enable", 32'(eng_mb), 32'd14);
    done_pulse(1'b0);

    finish_run();
  end
endmodule